// File: doc/BRIEF.md
# Priority Pin Crossbar

This block places a fixed set of on-chip peripheral signals onto a bank of general-purpose pins. The signals are visited in a fixed priority order, and each signal that is requested takes the lowest-numbered pin that is free and not marked to be passed over. Pins that no signal claims stay plain GPIO. Signals that flow into a peripheral are taken from their routed pin. Each pin has its own settings for digital or analog input and for open-drain or push-pull drive.

The assignment is combinational, computed from the current enable and skip settings. All outputs are registered, so a change in the configuration shows at the pins one clock later. A global enable holds the whole crossbar off, and while it is off every pin is GPIO. The SPI slave-select signal takes part only in four-wire mode. When the requested signals outnumber the free pins, the signals left over are not routed and a sticky flag is raised.

Top module: `pin_crossbar`

## Requirements
- R1: Signals are ranked by a fixed index, from highest priority to lowest: 0 UART transmit, 1 UART receive, 2 CAN transmit, 3 CAN receive, 4 SPI clock, 5 SPI master-in, 6 SPI master-out, 7 SPI slave select, 8 I2C data, 9 I2C clock, 10 comparator 0 synchronous, 11 comparator 0 asynchronous, 12 comparator 1 synchronous, 13 comparator 1 asynchronous, 14 system clock out, 15 to 20 PCA channels 0 to 5, 21 PCA external clock, 22 timer 0 input, 23 timer 1 input, 24 LIN transmit, 25 LIN receive. Bit k of each signal vector is signal k.
- R2: Each requested signal takes the lowest-numbered pin that is not skipped and not already taken by a higher-priority signal. Pin index p is port p/8, bit p%8.
- R3: A pin whose `pin_skip` bit is 1 never carries a peripheral signal. It keeps its GPIO value and drive request.
- R4: While `xbar_en` is 0, every pin carries `gpio_out`/`gpio_oe`, and every `sig_in` bit is 0.
- R5: The slave select signal (index 7) is requested only when `sig_en[7]` and `spi_4wire` are both 1. In three-wire mode it uses no pin and does not shift later signals.
- R6: A pin whose `pin_digital` bit is 0 is analog. Its `pin_oe`, `pin_pullup` and `pin_out` are 0, and it reads as 0 on `gpio_in` and on any `sig_in` routed to it.
- R7: The top `NUM_DIG_ONLY` pins are always digital, whatever their `pin_digital` bit.
- R8: On a digital pin with value v and drive request r (from the routed signal's `sig_oe`, otherwise from `gpio_oe`), `pin_out` = v. In push-pull mode (`pin_pushpull` = 1) `pin_oe` = r. In open-drain mode `pin_oe` = r AND NOT v, and `pin_pullup` = 1.
- R9: When the crossbar is on and the requested signals outnumber the non-skipped pins, the signals past the last free pin are not routed. `overflow` then goes to 1 and stays 1 until reset.
- R10: All outputs are registered, with one clock from input to output. During reset every output is 0.
- R11: An input signal routed to pin p reads `pin_in[p]` through the register stage. A requested signal that got no pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xbar_en | input | 1 | Global crossbar enable |
| spi_4wire | input | 1 | SPI four-wire mode; slave select needs a pin |
| sig_en | input | N_SIG (26) | Per-signal request bits, indexed per R1 |
| sig_out | input | N_SIG | Value each peripheral drives onto its pin |
| sig_oe | input | N_SIG | Drive request from each peripheral |
| sig_in | output | N_SIG | Pin value returned to each peripheral |
| pin_skip | input | NUM_PINS | 1 = pass this pin over during assignment |
| pin_digital | input | NUM_PINS | 1 = digital input, 0 = analog |
| pin_pushpull | input | NUM_PINS | 1 = push-pull, 0 = open-drain |
| gpio_out | input | NUM_PINS | GPIO output value |
| gpio_oe | input | NUM_PINS | GPIO drive request |
| gpio_in | output | NUM_PINS | Registered digital pin input |
| pin_in | input | NUM_PINS | Pad input values |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_pullup | output | NUM_PINS | Weak pull-up enables |
| overflow | output | 1 | Sticky: requested signals exceeded the free pins |

## Verification
The bench builds the block with `NUM_PINS` = 12 and `NUM_DIG_ONLY` = 1. With only twelve pins, enabling all 26 signals runs out of pins quickly, so the sticky overflow and the dropped low-priority signals are easy to reach. Pin 11 becomes the always-digital pin, so the analog override can be tried against it. A small random run over enables, skip masks and pad modes then compares every pin and signal against an independent sequential model of the assignment.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int N_SIG = 26;

    // Signal index equals priority rank (0 = highest).
    typedef enum int {
        SIG_UART_TX   = 0,
        SIG_UART_RX   = 1,
        SIG_CAN_TX    = 2,
        SIG_CAN_RX    = 3,
        SIG_SPI_CLK   = 4,
        SIG_SPI_MI    = 5,
        SIG_SPI_MO    = 6,
        SIG_SPI_SEL   = 7,
        SIG_I2C_DAT   = 8,
        SIG_I2C_CLK   = 9,
        SIG_CMP0_SYN  = 10,
        SIG_CMP0_ASY  = 11,
        SIG_CMP1_SYN  = 12,
        SIG_CMP1_ASY  = 13,
        SIG_CLK_OUT   = 14,
        SIG_PCA_CH0   = 15,
        SIG_PCA_CH5   = 20,
        SIG_PCA_ECLK  = 21,
        SIG_TMR0_IN   = 22,
        SIG_TMR1_IN   = 23,
        SIG_LIN_TX    = 24,
        SIG_LIN_RX    = 25
    } sig_id_e;

endpackage

// File: rtl/xbar_alloc.sv
// Rank-matching pin allocator: the k-th requested signal meets the k-th free pin.
module xbar_alloc #(
    parameter int NP = 33,
    parameter int NS = 26
) (
    input  logic [NS-1:0]                     sig_req,
    input  logic [NP-1:0]                     pin_skip,
    output logic [NP-1:0]                     pin_hit,
    output logic [NP-1:0][$clog2(NS)-1:0]     pin_sig,
    output logic [NS-1:0]                     sig_hit,
    output logic [NS-1:0][$clog2(NP)-1:0]     sig_pin,
    output logic                              short_of_pins
);
    localparam int SW = $clog2(NS);
    localparam int PW = $clog2(NP);
    localparam int RW = $clog2(NP + NS + 1);

    logic [NP-1:0][RW-1:0] pin_rank;
    logic [NS-1:0][RW-1:0] sig_rank;
    logic [RW-1:0]         n_free;
    logic [RW-1:0]         n_req;

    always_comb begin
        n_free = '0;
        for (int p = 0; p < NP; p++) begin
            pin_rank[p] = n_free;
            if (!pin_skip[p]) n_free = n_free + RW'(1);
        end
        n_req = '0;
        for (int s = 0; s < NS; s++) begin
            sig_rank[s] = n_req;
            if (sig_req[s]) n_req = n_req + RW'(1);
        end
        pin_hit = '0;
        pin_sig = '0;
        sig_hit = '0;
        sig_pin = '0;
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < NS; s++) begin
                if (!pin_skip[p] && sig_req[s] && (sig_rank[s] == pin_rank[p])) begin
                    pin_hit[p] = 1'b1;
                    pin_sig[p] = SW'(s);
                    sig_hit[s] = 1'b1;
                    sig_pin[s] = PW'(p);
                end
            end
        end
        short_of_pins = (n_req > n_free);
    end

    // Guards on the allocator result.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            p_skip_free_r3: assert (!(pin_hit[p] && pin_skip[p]))
                else $error("skipped pin %0d carries a signal", p);
        end
        p_route_count_r2: assert (RW'($countones(sig_hit)) == (short_of_pins ? n_free : n_req))
            else $error("routed signal count mismatch");
        p_pins_used_r9: assert (RW'($countones(pin_hit)) == RW'($countones(sig_hit)))
            else $error("pin and signal hit counts differ");
    end

endmodule

// File: rtl/xbar_pad.sv
// Per-pin drive shaping: analog gating, open-drain or push-pull.
module xbar_pad (
    input  logic digital,
    input  logic push_pull,
    input  logic value,
    input  logic drive,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_pu
);
    always_comb begin
        pad_out = digital & value;
        pad_oe  = digital & drive & (push_pull | ~value);
        pad_pu  = digital & ~push_pull;
    end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
    import xbar_pkg::*;
#(
    parameter int NUM_PINS     = 33,
    parameter int NUM_DIG_ONLY = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xbar_en,
    input  logic                spi_4wire,
    input  logic [N_SIG-1:0]    sig_en,
    input  logic [N_SIG-1:0]    sig_out,
    input  logic [N_SIG-1:0]    sig_oe,
    output logic [N_SIG-1:0]    sig_in,
    input  logic [NUM_PINS-1:0] pin_skip,
    input  logic [NUM_PINS-1:0] pin_digital,
    input  logic [NUM_PINS-1:0] pin_pushpull,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_PINS-1:0] gpio_oe,
    output logic [NUM_PINS-1:0] gpio_in,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pullup,
    output logic                overflow
);
    localparam int SW       = $clog2(N_SIG);
    localparam int PW       = $clog2(NUM_PINS);
    localparam int FIRST_DO = NUM_PINS - NUM_DIG_ONLY;

    typedef struct packed {
        logic [NUM_PINS-1:0] pin_out;
        logic [NUM_PINS-1:0] pin_oe;
        logic [NUM_PINS-1:0] pin_pu;
        logic [NUM_PINS-1:0] gpio_in;
        logic [N_SIG-1:0]    sig_in;
        logic                ovf;
    } state_t;

    state_t state_d, state_q;

    logic [N_SIG-1:0]              sig_req;
    logic [NUM_PINS-1:0]           pin_hit;
    logic [NUM_PINS-1:0][SW-1:0]   pin_sig;
    logic [N_SIG-1:0]              sig_hit;
    logic [N_SIG-1:0][PW-1:0]      sig_pin;
    logic                          short_of_pins;
    logic [NUM_PINS-1:0]           dig_eff, dig_in;
    logic [NUM_PINS-1:0]           val, drv, pad_out, pad_oe, pad_pu;

    always_comb begin
        sig_req              = sig_en;
        sig_req[SIG_SPI_SEL] = sig_en[SIG_SPI_SEL] & spi_4wire;
    end

    xbar_alloc #(.NP(NUM_PINS), .NS(N_SIG)) u_alloc (
        .sig_req       (sig_req),
        .pin_skip      (pin_skip),
        .pin_hit       (pin_hit),
        .pin_sig       (pin_sig),
        .sig_hit       (sig_hit),
        .sig_pin       (sig_pin),
        .short_of_pins (short_of_pins)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if (p >= FIRST_DO) begin : g_dig_only
            assign dig_eff[p] = 1'b1;
        end else begin : g_mixed
            assign dig_eff[p] = pin_digital[p];
        end
        assign val[p] = (xbar_en && pin_hit[p]) ? sig_out[pin_sig[p]] : gpio_out[p];
        assign drv[p] = (xbar_en && pin_hit[p]) ? sig_oe[pin_sig[p]]  : gpio_oe[p];

        xbar_pad u_pad (
            .digital   (dig_eff[p]),
            .push_pull (pin_pushpull[p]),
            .value     (val[p]),
            .drive     (drv[p]),
            .pad_out   (pad_out[p]),
            .pad_oe    (pad_oe[p]),
            .pad_pu    (pad_pu[p])
        );
    end

    assign dig_in = dig_eff & pin_in;

    always_comb begin
        state_d         = state_q;
        state_d.pin_out = pad_out;
        state_d.pin_oe  = pad_oe;
        state_d.pin_pu  = pad_pu;
        state_d.gpio_in = dig_in;
        for (int s = 0; s < N_SIG; s++) begin
            state_d.sig_in[s] = xbar_en & sig_hit[s] & dig_in[sig_pin[s]];
        end
        state_d.ovf = state_q.ovf | (xbar_en & short_of_pins);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pin_out    = state_q.pin_out;
    assign pin_oe     = state_q.pin_oe;
    assign pin_pullup = state_q.pin_pu;
    assign gpio_in    = state_q.gpio_in;
    assign sig_in     = state_q.sig_in;
    assign overflow   = state_q.ovf;

    p_xbar_off_no_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_en |=> (state_q.sig_in == '0))
        else $error("routed input while crossbar off");

    p_analog_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.pin_oe | state_q.pin_pu) & ~$past(dig_eff)) == '0)
        else $error("analog pin driven or pulled up");

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ovf |=> state_q.ovf)
        else $error("overflow flag cleared");

    p_sel_3wire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_4wire |=> !state_q.sig_in[SIG_SPI_SEL])
        else $error("slave select routed in three-wire mode");

endmodule

// File: tb/pin_crossbar_bench.sv
module pin_crossbar_bench;
    import xbar_pkg::*;

    localparam int NP = 12;
    localparam int ND = 1;
    localparam int W  = 4 * NP + N_SIG + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              xen = 1'b0, spi4 = 1'b0;
    logic [N_SIG-1:0]  sen = '0, sout = '0, soe = '1;
    logic [NP-1:0]     skip = '0, dig = '1, pp = '1, gout = '0, goe = '1, pin_in = '0;
    logic [N_SIG-1:0]  sin;
    logic [NP-1:0]     gin, pout, poe, ppu;
    logic              ovf;

    pin_crossbar #(.NUM_PINS(NP), .NUM_DIG_ONLY(ND)) u_pin_crossbar (
        .clk(clk), .rst_n(rst_n), .xbar_en(xen), .spi_4wire(spi4),
        .sig_en(sen), .sig_out(sout), .sig_oe(soe), .sig_in(sin),
        .pin_skip(skip), .pin_digital(dig), .pin_pushpull(pp),
        .gpio_out(gout), .gpio_oe(goe), .gpio_in(gin), .pin_in(pin_in),
        .pin_out(pout), .pin_oe(poe), .pin_pullup(ppu), .overflow(ovf)
    );

    typedef struct {
        logic [W-1:0] v;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic ovf_model = 1'b0;

    function automatic logic [W-1:0] got_vec();
        return {pout, poe, ppu, gin, sin, ovf};
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Sequential reference: walk signals in priority order, advance a pin pointer.
    task automatic push(string tag);
        int owner[NP];
        int spin[N_SIG];
        int p = 0;
        logic [NP-1:0] e_out = '0, e_oe = '0, e_pu = '0, e_gin = '0;
        logic [N_SIG-1:0] e_sin = '0;
        exp_t e;
        for (int i = 0; i < NP; i++) owner[i] = -1;
        for (int s = 0; s < N_SIG; s++) spin[s] = -1;
        if (xen) begin
            for (int s = 0; s < N_SIG; s++) begin
                if (sen[s] && (s != 7 || spi4)) begin
                    while (p < NP && skip[p]) p++;
                    if (p < NP) begin
                        owner[p] = s;
                        spin[s]  = p;
                        p++;
                    end else begin
                        ovf_model = 1'b1;
                    end
                end
            end
        end
        for (int i = 0; i < NP; i++) begin
            logic d, v, r;
            d = dig[i] || (i >= NP - ND);
            v = (owner[i] >= 0) ? sout[owner[i]] : gout[i];
            r = (owner[i] >= 0) ? soe[owner[i]]  : goe[i];
            e_out[i] = d & v;
            e_oe[i]  = d & r & (pp[i] | ~v);
            e_pu[i]  = d & ~pp[i];
            e_gin[i] = d & pin_in[i];
        end
        for (int s = 0; s < N_SIG; s++) begin
            if (spin[s] >= 0) e_sin[s] = e_gin[spin[s]];
        end
        e.v   = {e_out, e_oe, e_pu, e_gin, e_sin, ovf_model};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, got_vec(), e.v);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset state", got_vec(), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: crossbar off, all pins GPIO, no routed inputs
        sen = '1; gout = 12'hA5C; pin_in = 12'h3F0; goe = 12'hF0F;
        push("R4 crossbar off");

        // R1 R2 R8 R11: two UART signals on pins 0 and 1
        xen = 1'b1; sen = '0; sen[SIG_UART_TX] = 1'b1; sen[SIG_UART_RX] = 1'b1;
        sout = '0; sout[SIG_UART_TX] = 1'b1; soe = '1; soe[SIG_UART_RX] = 1'b0;
        pin_in = 12'h002;
        push("R2 uart on pins 0 and 1");
        push("R11 receive routed from pin 1");

        // R3: skip pins 0 and 2
        skip = 12'h005;
        push("R3 skipped pins passed over");

        // R1: priority across the list
        skip = '0; sen = '0; sen[SIG_LIN_RX] = 1'b1; sen[SIG_UART_TX] = 1'b1; sen[SIG_PCA_CH0] = 1'b1;
        sout = '1; pin_in = 12'h004;
        push("R1 priority order");

        // R5: slave select in three- and four-wire modes
        sen = '0; sen[SIG_SPI_CLK] = 1'b1; sen[SIG_SPI_MI] = 1'b1; sen[SIG_SPI_MO] = 1'b1;
        sen[SIG_SPI_SEL] = 1'b1; sen[SIG_I2C_DAT] = 1'b1; pin_in = 12'h0FF;
        spi4 = 1'b0;
        push("R5 three-wire select unrouted");
        spi4 = 1'b1;
        push("R5 four-wire select routed");

        // R8: open-drain behaviour
        pp = 12'h0F0; sout = 26'h155_5555; soe = '1; gout = 12'hC3C;
        push("R8 open-drain and push-pull");

        // R6: analog pins quiet and read 0
        dig = 12'hF0F; pin_in = '1;
        push("R6 analog pins");

        // R7: top pin stays digital
        dig = 12'h000; gout = 12'hFFF; goe = '1;
        push("R7 digital-only pin");

        // R9: overflow with all signals requested, then sticky
        dig = '1; pp = '1; sen = '1; skip = 12'h010; pin_in = 12'hABC;
        push("R9 overflow raised");
        sen = '0; sen[SIG_UART_TX] = 1'b1;
        push("R9 overflow sticky");

        // R2: pseudo-random configurations
        for (int i = 0; i < 10; i++) begin
            xen    = 1'($urandom);
            spi4   = 1'($urandom);
            sen    = N_SIG'($urandom) & N_SIG'($urandom);
            sout   = N_SIG'($urandom);
            soe    = N_SIG'($urandom);
            skip   = NP'($urandom) & NP'($urandom);
            dig    = NP'($urandom) | NP'($urandom);
            pp     = NP'($urandom);
            gout   = NP'($urandom);
            goe    = NP'($urandom);
            pin_in = NP'($urandom);
            push("R2 random configuration");
        end

        wait (q.size() == 0);
        @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule